// File: doc/BRIEF.md
# Auto-Increment Burst Write Buffer

This block sits on a 16-bit multiplexed address/data register bus. It fills a word buffer through one fixed register address. The host first loads a register address with an address-write strobe. It then issues data-write strobes on the same bus lines. When the latched address selects the buffer, each data-write strobe stores the bus word at an internal index. The index then moves on by one. Repeated writes to one bus address therefore stream into successive buffer locations, which suits bulk transfers such as filling a frame store.

All bus strobes are asynchronous to the system clock. Each strobe passes through a two-flop synchronizer, and its edges are detected in the clock domain. The bus word is captured when the rising edge of the data-write strobe is detected. The index advances when the falling edge is detected. A second register address, written with any data, returns the index to zero. Consumer logic reads the buffer through a synchronous read port that has one cycle of latency.

Top module: `burst_fill_buffer`

## Requirements
- R1: A data-write strobe changes the buffer and the index only while the latched bus address is 0x7000 (or 0x7001 for the clear of R7). Data writes while any other address is latched change neither the buffer nor the index.
- R2: On the rising edge of the data-write strobe, the word on the bus is stored at the current index. A bus change after that edge, while the strobe is still high, does not alter the stored word.
- R3: On the falling edge of the data-write strobe, the index advances by one. Consecutive data writes with no new address write land in successive locations.
- R4: The buffer holds 64 words of 16 bits. After location 63 is written, the index wraps to 0.
- R5: While rst_n is low, the index and the latched address are cleared and rd_data is 0. After reset, the first buffer write lands at location 0.
- R6: An address write of 0x7000 while the buffer is already selected does not reset the index.
- R7: A data write while the latched address is 0x7001 sets the index to 0, whatever the data is, and leaves the buffer contents unchanged.
- R8: rd_data shows the word at location rd_idx exactly one clock after rd_idx is presented. Back-to-back reads of different indices return one word per cycle.
- R9: A strobe held high or low for many cycles acts exactly once per edge: one store per rising edge and one index step per falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 16 | Multiplexed address/data bus value |
| addr_wr | input | 1 | Address-write strobe, active high, asynchronous |
| data_wr | input | 1 | Data-write strobe, active high, asynchronous |
| rd_idx | input | 6 | Buffer location for the consumer read port |
| rd_data | output | 16 | Word read from the buffer, one cycle after rd_idx |

## Verification
Each strobe edge takes effect on the third rising clock edge after the strobe changes. Two edges are spent in the synchronizer and one in the register that acts on the detected edge. The bench therefore holds each strobe level, and the bus word, for five cycles before the next change. A read result is due one clock after rd_idx is driven, so the bench moves rd_idx on each falling edge and compares rd_data on the next falling edge. The buffer's write position is never read directly. Instead, every index expectation (advance, wrap, clear, no clear on reselect, no change on a foreign address) is checked by where the next stored word appears.

// File: rtl/fill_pkg.sv
`timescale 1ns/1ps
package fill_pkg;
   localparam int unsigned BUS_W       = 16;
   localparam logic [BUS_W-1:0] DEF_BUF_ADDR = 16'h7000;
   localparam logic [BUS_W-1:0] DEF_CTL_ADDR = 16'h7001;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_BUF  = 2'd1,
      SEL_CTL  = 2'd2
   } sel_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_s;
endpackage

// File: rtl/fill_strobe_sync.sv
`timescale 1ns/1ps
module fill_strobe_sync
   import fill_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  strobe_in,
   output edge_s edges
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fill_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;
   logic              synced;

   if (STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[0], strobe_in};
      end
   end else begin : g_deep
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], strobe_in};
      end
   end

   assign synced = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= synced;
   end

   always_comb begin
      edges.rise = synced & ~last_q;
      edges.fall = ~synced & last_q;
   end

   // R9: a detected edge is a single-cycle pulse
   p_one_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      edges.rise |=> !edges.rise);
   p_one_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      edges.fall |=> !edges.fall);
   p_no_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(edges.rise && edges.fall));
endmodule

// File: rtl/fill_addr_decode.sv
`timescale 1ns/1ps
module fill_addr_decode
   import fill_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 16,
   parameter logic [ADDR_W-1:0]    BUF_ADDR = 16'h7000,
   parameter logic [ADDR_W-1:0]    CTL_ADDR = 16'h7001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output sel_e              sel
);
   if (BUF_ADDR == CTL_ADDR) begin : g_bad_map
      $error("fill_addr_decode: buffer and control addresses must differ");
   end

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= addr_in;
   end

   always_comb begin
      if (addr_q == BUF_ADDR)      sel = SEL_BUF;
      else if (addr_q == CTL_ADDR) sel = SEL_CTL;
      else                         sel = SEL_NONE;
   end

   // R6: the latched address changes only on an address-write edge
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_q));
   // R1: a load takes the bus value
   p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_q == $past(addr_in));
endmodule

// File: rtl/fill_index_ctr.sv
`timescale 1ns/1ps
module fill_index_ctr #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             clear,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("fill_index_ctr: DEPTH must be at least 2");
   end

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          idx_q <= '0;
      else if (clear)      idx_q <= '0;
      else if (step) begin
         if (idx_q == LAST) idx_q <= '0;
         else               idx_q <= idx_q + 1'b1;
      end
   end

   assign idx = idx_q;

   // R3: a step moves the index by one below the top
   p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && idx_q != LAST) |=> idx_q == $past(idx_q) + 1'b1);
   // R4: the top location wraps to zero
   p_idx_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && idx_q == LAST) |=> idx_q == '0);
   // R7: a clear returns to zero
   p_idx_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> idx_q == '0);
   // R6: with no step and no clear, the index holds
   p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(idx_q));
endmodule

// File: rtl/fill_word_store.sv
`timescale 1ns/1ps
module fill_word_store #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] words [DEPTH];
   logic [DEPTH-1:0]  word_we;

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      assign word_we[g] = we && (waddr == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (word_we[g]) words[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rdata <= '0;
      else if (raddr < IDX_W'(DEPTH - 1) || raddr == IDX_W'(DEPTH - 1))
                                  rdata <= words[raddr];
      else                        rdata <= '0;
   end

   // R2: at most one location is written per cycle
   p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(word_we));
   // R8: a write to the location being read shows one cycle later
   p_rd_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == raddr) |=> ($stable(raddr) |-> ##1 rdata == $past(wdata, 2)));
endmodule

// File: rtl/burst_fill_buffer.sv
`timescale 1ns/1ps
module burst_fill_buffer
   import fill_pkg::*;
#(
   parameter int unsigned          DATA_W      = 16,
   parameter int unsigned          DEPTH       = 64,
   parameter int unsigned          SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0]    BUF_ADDR    = DEF_BUF_ADDR,
   parameter logic [DATA_W-1:0]    CTL_ADDR    = DEF_CTL_ADDR,
   localparam int unsigned         IDX_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              addr_wr,
   input  logic              data_wr,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 2) begin : g_bad_width
      $error("burst_fill_buffer: DATA_W too small");
   end

   edge_s            addr_edge;
   edge_s            data_edge;
   sel_e             sel;
   logic [IDX_W-1:0] wr_idx;
   logic             store_en;
   logic             step_en;
   logic             clear_en;

   fill_strobe_sync #(.STAGES(SYNC_STAGES)) u_addr_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_in (addr_wr),
      .edges     (addr_edge)
   );

   fill_strobe_sync #(.STAGES(SYNC_STAGES)) u_data_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_in (data_wr),
      .edges     (data_edge)
   );

   fill_addr_decode #(
      .ADDR_W   (DATA_W),
      .BUF_ADDR (BUF_ADDR),
      .CTL_ADDR (CTL_ADDR)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (addr_edge.rise),
      .addr_in (bus_data),
      .sel     (sel)
   );

   assign store_en = data_edge.rise && (sel == SEL_BUF);
   assign step_en  = data_edge.fall && (sel == SEL_BUF);
   assign clear_en = data_edge.rise && (sel == SEL_CTL);

   fill_index_ctr #(.DEPTH(DEPTH)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step_en),
      .clear (clear_en),
      .idx   (wr_idx)
   );

   fill_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (store_en),
      .waddr (wr_idx),
      .wdata (bus_data),
      .raddr (rd_idx),
      .rdata (rd_data)
   );

   // R1: the index moves only on data edges
   p_idx_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_edge.rise && !data_edge.fall) |=> $stable(wr_idx));
   // R9: a store and a step never coincide
   p_store_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_en && step_en));
endmodule

// File: tb/tb_burst_fill_buffer.sv
`timescale 1ns/1ps
module tb_burst_fill_buffer;
   localparam int DEPTH = 64;
   localparam logic [15:0] A_BUF = 16'h7000;
   localparam logic [15:0] A_CTL = 16'h7001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_data = '0;
   logic        addr_wr = 1'b0;
   logic        data_wr = 1'b0;
   logic [5:0]  rd_idx = '0;
   logic [15:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] ref_mem [DEPTH];
   bit          ref_ok  [DEPTH];
   int          ref_idx = 0;
   logic [15:0] ref_addr = '0;

   always #10 clk = ~clk;

   burst_fill_buffer dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_data (bus_data),
      .addr_wr  (addr_wr),
      .data_wr  (data_wr),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data)
   );

   function automatic int next_idx(int i);
      return (i == DEPTH - 1) ? 0 : i + 1;
   endfunction

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic addr_write(logic [15:0] a);
      bus_data = a;
      cyc(1);
      addr_wr = 1'b1;
      cyc(5);
      addr_wr = 1'b0;
      cyc(5);
      ref_addr = a;
   endtask

   task automatic data_write(logic [15:0] d, int hold);
      bus_data = d;
      cyc(1);
      data_wr = 1'b1;
      cyc(hold);
      data_wr = 1'b0;
      cyc(hold);
      if (ref_addr == A_BUF) begin
         ref_mem[ref_idx] = d;
         ref_ok[ref_idx]  = 1'b1;
         ref_idx = next_idx(ref_idx);
      end else if (ref_addr == A_CTL) begin
         ref_idx = 0;
      end
   endtask

   task automatic read_one(string req, int i, logic [15:0] exp);
      rd_idx = 6'(i);
      cyc(1);
      chk(req, rd_data, exp);
   endtask

   // back-to-back reads: a new index every cycle, result one cycle later
   task automatic scan_all(string req);
      for (int i = 0; i < DEPTH; i++) begin
         rd_idx = 6'(i);
         cyc(1);
         if (ref_ok[i]) chk(req, rd_data, ref_mem[i]);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int r;
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;

      // R5: reset state
      cyc(3);
      chk("R5 reset rd_data", rd_data, 16'h0000);
      rst_n = 1'b1;
      cyc(2);

      // R5/R2/R3: first writes after reset start at 0 and advance
      addr_write(A_BUF);
      data_write(16'hA001, 5);
      data_write(16'hA002, 5);
      data_write(16'hA003, 5);
      read_one("R5 first word at 0", 0, 16'hA001);
      read_one("R3 second word at 1", 1, 16'hA002);
      read_one("R3 third word at 2", 2, 16'hA003);

      // R8: exact one-cycle latency on back-to-back reads
      rd_idx = 6'd2; cyc(1);
      rd_idx = 6'd0; cyc(1);
      chk("R8 pipelined read", rd_data, 16'hA001);
      rd_idx = 6'd1; cyc(1);
      chk("R8 pipelined read", rd_data, 16'hA002);

      // R2: bus change after the rising edge is not stored
      bus_data = 16'h5555;
      cyc(1);
      data_wr = 1'b1;
      cyc(6);
      bus_data = 16'hDEAD;
      cyc(4);
      data_wr = 1'b0;
      cyc(5);
      ref_mem[3] = 16'h5555; ref_ok[3] = 1'b1; ref_idx = 4;
      read_one("R2 capture at rise", 3, 16'h5555);

      // R9: long strobe holds still act once
      data_write(16'hB004, 40);
      data_write(16'hB005, 5);
      read_one("R9 long hold store", 4, 16'hB004);
      read_one("R9 single step", 5, 16'hB005);

      // R6: reselecting the buffer keeps the index
      addr_write(A_BUF);
      data_write(16'hC006, 5);
      read_one("R6 reselect no reset", 6, 16'hC006);

      // R1: foreign address leaves buffer and index alone
      addr_write(16'h1234);
      data_write(16'hEEEE, 5);
      data_write(16'hEEEF, 5);
      scan_all("R1 buffer untouched");
      addr_write(A_BUF);
      data_write(16'hC007, 5);
      read_one("R1 index untouched", 7, 16'hC007);

      // R7: control address clears index, buffer intact
      addr_write(A_CTL);
      data_write(16'h0BAD, 5);
      scan_all("R7 buffer intact");
      addr_write(A_BUF);
      data_write(16'hD000, 5);
      read_one("R7 index cleared", 0, 16'hD000);
      read_one("R7 neighbour intact", 1, 16'hA002);

      // R4: wrap after location 63
      addr_write(A_CTL);
      data_write(16'h0000, 5);
      addr_write(A_BUF);
      for (int i = 0; i < DEPTH + 3; i++) data_write(16'h4000 + 16'(i), 4);
      read_one("R4 wrap to 0", 0, 16'h4040);
      read_one("R4 wrap to 2", 2, 16'h4042);
      read_one("R4 top location", 63, 16'h403F);
      read_one("R4 untouched after wrap", 3, 16'h4003);

      // random mix of operations
      for (int n = 0; n < 250; n++) begin
         r = int'($urandom_range(0, 9));
         d = 16'($urandom);
         if (r < 7)       data_write(d, 4 + int'($urandom_range(0, 3)));
         else if (r == 7) addr_write(A_BUF);
         else if (r == 8) addr_write(A_CTL);
         else begin
            if (d == A_BUF || d == A_CTL) d = 16'h0100;
            addr_write(d);
         end
         if (n % 50 == 49) scan_all("R3 random burst contents");
      end
      scan_all("R3 random final contents");

      // R5: mid-run reset clears index
      rst_n = 1'b0;
      cyc(2);
      chk("R5 rd_data in reset", rd_data, 16'h0000);
      rst_n = 1'b1;
      cyc(2);
      ref_idx = 0;
      ref_addr = '0;
      addr_write(A_BUF);
      data_write(16'hF00D, 5);
      read_one("R5 write after reset at 0", 0, 16'hF00D);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule